// File: doc/BRIEF.md
# Prioritized Outbound Window Decoder

This block takes each internal-bus address and decides whether it belongs to one of three outbound windows. A hit means the transaction should go out as a bus initiator request through the matching window. Only the top address byte is compared. Each window has an 8-bit base and an 8-bit mask, and a set mask bit means that bit position is ignored. The smallest window is therefore 16 MB, and each extra masked bit doubles its size.

On a hit, the masked positions of the upper byte are replaced by the window's translation byte, and the unmasked positions keep the incoming address bits. The lower 24 bits always pass through unchanged. Windows may overlap. Window 0 beats windows 1 and 2, and window 1 beats window 2.

Software sets the windows through a simple write port. Each write picks a window index, a field and a data byte. A parameter adds an optional output register stage.

Top module: `owd_decoder`

## Requirements
- R1: After reset every window is disabled, with base, mask and translation cleared, so every lookup misses.
- R2: An enabled window matches when `(addr[31:24] & ~mask) == (base & ~mask)`. Base bits under set mask bits have no effect.
- R3: A window whose enable bit is 0 never matches, even when its base and mask would match the address.
- R4: When several enabled windows match, window 0 is selected over 1 and 2, and window 1 over 2.
- R5: `out_sel` has at most one bit set, bit i meaning window i, and is all zeros on a miss. `out_hit` is 1 exactly when `out_sel` is non-zero.
- R6: On a hit, `out_addr[31:24]` equals `(addr[31:24] & ~mask) | (xlat & mask)` of the selected window. On a miss it equals `addr[31:24]`.
- R7: `out_addr[23:0]` equals the input's bits 23:0, and those bits have no effect on hit or select.
- R8: With `REG_OUT=1`, results appear one clock after the cycle in which `in_valid` is high, and `out_valid` is `in_valid` delayed one cycle. With `REG_OUT=0`, results are combinational. Whenever `out_valid` is 0, `out_hit` and `out_sel` are 0.
- R9: A write with `cfg_we=1` updates the field chosen by `cfg_field` for window `cfg_win`: 0 is base, 1 is mask, 2 is translation, and 3 is enable (taken from `cfg_data[0]`). A write naming a window index of 3 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window index of the write |
| cfg_field | input | 2 | Field code: 0 base, 1 mask, 2 translation, 3 enable |
| cfg_data | input | 8 | Write data |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 32 | Internal-bus address |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Address falls in an enabled window |
| out_sel | output | 3 | One-hot selected window |
| out_addr | output | 32 | Address with translated upper byte |

## Verification
The bench builds the decoder with its defaults of three windows and an 8-bit compare byte, and with `REG_OUT=1`. That makes the one-cycle latency and the zeroing of idle outputs observable. Because the compared field is only 8 bits wide, every one of the 256 upper-byte values is swept under each of five window configurations. The configurations cover the reset state, fully overlapping windows, a disabled top-priority window, an ignored out-of-range write, and base bits hidden under the mask. The lower 24 bits change with every address, so their pass-through and their lack of effect on the decode are checked on every lookup.

// File: rtl/owd_pkg.sv
package owd_pkg;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_XLAT = 2'd2,
    FLD_EN   = 2'd3
  } cfg_field_e;

endpackage

// File: rtl/owd_win_regs.sv
module owd_win_regs #(
  parameter int NUM_WIN = 3,
  parameter int CMP_W   = 8,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_win,
  input  logic [1:0]                      cfg_field,
  input  logic [CMP_W-1:0]                cfg_data,
  output logic [NUM_WIN-1:0][CMP_W-1:0]   base_o,
  output logic [NUM_WIN-1:0][CMP_W-1:0]   mask_o,
  output logic [NUM_WIN-1:0][CMP_W-1:0]   xlat_o,
  output logic [NUM_WIN-1:0]              en_o
);
  import owd_pkg::*;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [CMP_W-1:0] base_q, base_d, mask_q, mask_d, xlat_q, xlat_d;
    logic             en_q, en_d;
    logic             sel_w;

    assign sel_w = cfg_we && (cfg_win == IDX_W'(w));

    always_comb begin
      base_d = base_q;
      mask_d = mask_q;
      xlat_d = xlat_q;
      en_d   = en_q;
      if (sel_w) begin
        case (cfg_field_e'(cfg_field))
          FLD_BASE: base_d = cfg_data;
          FLD_MASK: mask_d = cfg_data;
          FLD_XLAT: xlat_d = cfg_data;
          FLD_EN:   en_d   = cfg_data[0];
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        xlat_q <= '0;
        en_q   <= 1'b0;
      end else begin
        base_q <= base_d;
        mask_q <= mask_d;
        xlat_q <= xlat_d;
        en_q   <= en_d;
      end
    end

    assign base_o[w] = base_q;
    assign mask_o[w] = mask_q;
    assign xlat_o[w] = xlat_q;
    assign en_o[w]   = en_q;
  end

endmodule

// File: rtl/owd_win_match.sv
module owd_win_match #(
  parameter int NUM_WIN = 3,
  parameter int CMP_W   = 8
) (
  input  logic [CMP_W-1:0]              hi_byte,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] base_i,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] mask_i,
  input  logic [NUM_WIN-1:0]            en_i,
  output logic [NUM_WIN-1:0]            match_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [CMP_W-1:0] diff;
    assign diff       = (hi_byte ^ base_i[w]) & ~mask_i[w];
    assign match_o[w] = en_i[w] && (diff == '0);
  end

endmodule

// File: rtl/owd_prio_sel.sv
module owd_prio_sel #(
  parameter int NUM_WIN = 3,
  parameter int CMP_W   = 8
) (
  input  logic [NUM_WIN-1:0]            match_i,
  input  logic [CMP_W-1:0]              hi_byte,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] mask_i,
  input  logic [NUM_WIN-1:0][CMP_W-1:0] xlat_i,
  output logic [NUM_WIN-1:0]            sel_o,
  output logic [CMP_W-1:0]              xbyte_o
);

  logic taken;

  always_comb begin
    sel_o = '0;
    taken = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (match_i[w] && !taken) begin
        sel_o[w] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    xbyte_o = hi_byte;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_o[w]) xbyte_o = (hi_byte & ~mask_i[w]) | (xlat_i[w] & mask_i[w]);
    end
  end

endmodule

// File: rtl/owd_decoder.sv
module owd_decoder #(
  parameter int NUM_WIN = 3,
  parameter int CMP_W   = 8,
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_WIN)-1:0] cfg_win,
  input  logic [1:0]                 cfg_field,
  input  logic [CMP_W-1:0]           cfg_data,
  input  logic                       in_valid,
  input  logic [ADDR_W-1:0]          in_addr,
  output logic                       out_valid,
  output logic                       out_hit,
  output logic [NUM_WIN-1:0]         out_sel,
  output logic [ADDR_W-1:0]          out_addr
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int LOW_W = ADDR_W - CMP_W;

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [NUM_WIN-1:0][CMP_W-1:0] base_w, mask_w, xlat_w;
  logic [NUM_WIN-1:0]            en_w, match_w, sel_w;
  logic [CMP_W-1:0]              hi_byte, xbyte;

  assign hi_byte = in_addr[ADDR_W-1 -: CMP_W];

  owd_win_regs #(.NUM_WIN(NUM_WIN), .CMP_W(CMP_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_field(cfg_field), .cfg_data(cfg_data),
    .base_o(base_w), .mask_o(mask_w), .xlat_o(xlat_w), .en_o(en_w)
  );

  owd_win_match #(.NUM_WIN(NUM_WIN), .CMP_W(CMP_W)) u_match (
    .hi_byte(hi_byte), .base_i(base_w), .mask_i(mask_w), .en_i(en_w),
    .match_o(match_w)
  );

  owd_prio_sel #(.NUM_WIN(NUM_WIN), .CMP_W(CMP_W)) u_prio (
    .match_i(match_w), .hi_byte(hi_byte), .mask_i(mask_w), .xlat_i(xlat_w),
    .sel_o(sel_w), .xbyte_o(xbyte)
  );

  logic               hit_d;
  logic [NUM_WIN-1:0] sel_d;
  logic [ADDR_W-1:0]  addr_n;

  assign sel_d  = in_valid ? sel_w : '0;
  assign hit_d  = |sel_d;
  assign addr_n = {xbyte, in_addr[LOW_W-1:0]};

  if (REG_OUT) begin : g_reg
    logic               valid_q, hit_q;
    logic [NUM_WIN-1:0] sel_q;
    logic [ADDR_W-1:0]  addr_q, addr_d;

    always_comb begin
      addr_d = addr_q;
      if (in_valid) addr_d = addr_n;
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        valid_q <= 1'b0;
        hit_q   <= 1'b0;
        sel_q   <= '0;
        addr_q  <= '0;
      end else begin
        valid_q <= in_valid;
        hit_q   <= hit_d;
        sel_q   <= sel_d;
        addr_q  <= addr_d;
      end
    end

    assign out_valid = valid_q;
    assign out_hit   = hit_q;
    assign out_sel   = sel_q;
    assign out_addr  = addr_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_hit   = hit_d;
    assign out_sel   = sel_d;
    assign out_addr  = addr_n;
  end

endmodule

// File: rtl/owd_decoder_chk.sv
module owd_decoder_chk #(
  parameter int NUM_WIN = 3,
  parameter int CMP_W   = 8,
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_s,
  input logic               in_valid,
  input logic [ADDR_W-1:0]  in_addr,
  input logic               out_valid,
  input logic               out_hit,
  input logic [NUM_WIN-1:0] out_sel,
  input logic [ADDR_W-1:0]  out_addr
);
  localparam int LOW_W = ADDR_W - CMP_W;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(out_sel)); // R5

  AST_HIT_TRACKS_SEL: assert property (@(posedge clk) disable iff (!rst_s)
    out_hit == (out_sel != '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |-> (!out_hit && out_sel == '0)); // R8

  if (REG_OUT) begin : g_reg_chk
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> out_valid); // R8

    AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> out_addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])); // R7

    AST_MISS_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> (out_hit || out_addr[ADDR_W-1 -: CMP_W] == $past(in_addr[ADDR_W-1 -: CMP_W]))); // R6
  end else begin : g_comb_chk
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
      out_valid == in_valid); // R8

    AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_s)
      out_addr[LOW_W-1:0] == in_addr[LOW_W-1:0]); // R7

    AST_MISS_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_s)
      (out_hit || out_addr[ADDR_W-1 -: CMP_W] == in_addr[ADDR_W-1 -: CMP_W])); // R6
  end

endmodule

bind owd_decoder owd_decoder_chk #(
  .NUM_WIN(NUM_WIN), .CMP_W(CMP_W), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_s(rst_s), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_sel(out_sel), .out_addr(out_addr)
);

// File: tb/owd_decoder_test.sv
module owd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_win;
  logic [1:0]  cfg_field;
  logic [7:0]  cfg_data;
  logic        in_valid;
  logic [31:0] in_addr;
  logic        out_valid, out_hit;
  logic [2:0]  out_sel;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_base [3];
  logic [7:0] m_mask [3];
  logic [7:0] m_xlat [3];
  logic       m_en   [3];

  always #5 clk = ~clk;

  owd_decoder #(.NUM_WIN(3), .CMP_W(8), .ADDR_W(32), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_sel(out_sel), .out_addr(out_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: field codes 0 base, 1 mask, 2 translation, 3 enable (data bit 0)
  task automatic wr(input int win, input int fld, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'(win); cfg_field = 2'(fld); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (win < 3) begin
      case (fld)
        0: m_base[win] = data;
        1: m_mask[win] = data;
        2: m_xlat[win] = data;
        default: m_en[win] = data[0];
      endcase
    end
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    logic [2:0] es;
    logic [7:0] eb;
    es = 3'b000;
    eb = a[31:24];
    for (int w = 2; w >= 0; w--) begin
      if (m_en[w] && (((a[31:24] ^ m_base[w]) & ~m_mask[w]) == 8'h00)) begin
        es = 3'b000;
        es[w] = 1'b1;
        eb = (a[31:24] & ~m_mask[w]) | (m_xlat[w] & m_mask[w]);
      end
    end
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " R8 valid"}, 64'(out_valid), 64'd1);
    check(out_sel === es && out_hit === (es != 3'b000), {tag, " R4/R5 sel"},
          64'({out_hit, out_sel}), 64'({es != 3'b000, es}));
    check(out_addr === {eb, a[23:0]}, {tag, " R6/R7 addr"}, 64'(out_addr), 64'({eb, a[23:0]}));
  endtask

  task automatic sweep(input string tag, input int seed);
    for (int b = 0; b < 256; b++) begin
      logic [23:0] lo;
      lo = 24'((b * 32'h9E3779 + seed * 32'h1F123B) ^ 32'h5A5A5A);
      lookup({8'(b), lo}, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 3; w++) begin
      m_base[w] = 8'h00; m_mask[w] = 8'h00; m_xlat[w] = 8'h00; m_en[w] = 1'b0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_win = '0; cfg_field = '0; cfg_data = '0;
    in_valid = 1'b0; in_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0 && out_hit === 1'b0 && out_sel === 3'b000, "R1 reset outputs",
          64'({out_valid, out_hit, out_sel}), 64'd0);

    sweep("R1 all disabled", 1);

    wr(0, 0, 8'h40); wr(0, 1, 8'h00); wr(0, 2, 8'h80); wr(0, 3, 8'h01);
    wr(1, 0, 8'h40); wr(1, 1, 8'h3F); wr(1, 2, 8'hC0); wr(1, 3, 8'h01);
    wr(2, 0, 8'h00); wr(2, 1, 8'hFF); wr(2, 2, 8'h11); wr(2, 3, 8'h01);
    sweep("R4 overlap", 2);

    @(negedge clk);
    check(out_valid === 1'b0 && out_hit === 1'b0 && out_sel === 3'b000, "R8 idle outputs",
          64'({out_valid, out_hit, out_sel}), 64'd0);

    wr(0, 3, 8'hFE);
    sweep("R3 w0 disabled", 3);

    wr(3, 3, 8'h01); wr(3, 0, 8'h40); wr(3, 1, 8'hFF);
    sweep("R9 out-of-range write", 4);

    wr(2, 3, 8'h00);
    wr(1, 0, 8'hA5); wr(1, 1, 8'h0F); wr(1, 2, 8'h3C);
    sweep("R2 masked base", 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule